// File: doc/BRIEF.md
# E1 Basic Frame Aligner

This block recovers the E1 basic frame structure from a serial receive stream at 2.048 Mbit/s. It is clocked by the recovered bit clock and takes one line bit on every rising edge. A frame is 32 timeslots of 8 bits. Even frames carry the 7-bit alignment word `0011011` in bits 2 to 8 of timeslot 0. In odd frames, bit 2 of timeslot 0 is held at 1. The aligner searches for the alignment word one bit position at a time. It confirms a candidate across three frames and then reports lock. After lock it presents the timeslot and bit number of the bit currently on `rx_data`, a frame-start strobe and an odd-frame flag.

While locked, the aligner keeps checking timeslot 0 of every frame. Three alignment words in a row received in error send it back to search. When `alt_loss_en` is set, three odd frames in a row with bit 2 received as 0 also send it back to search. Both events raise a one-clock resync pulse. Multiframe alignment and line decoding belong to other blocks.

The state machine has four states:
- `ST_HUNT` slides the candidate position one bit at a time.
- `ST_GAP` checks that frame N+1 does not carry the alignment word.
- `ST_CONFIRM` checks that frame N+2 carries it again.
- `ST_LOCKED` is frame sync.

The named transitions are:
- `hunt_hit` (HUNT→GAP)
- `gap_ok` (GAP→CONFIRM)
- `gap_fail` (GAP→HUNT)
- `confirm_ok` (CONFIRM→LOCKED)
- `confirm_fail` (CONFIRM→HUNT)
- `loss` (LOCKED→HUNT)

The GAP, CONFIRM and LOCKED states are evaluated only on the last bit of timeslot 0.

Top module: `e1_frame_aligner`

## Requirements
- R1: After reset the block is in `ST_HUNT`, and `in_frame`, `resync_pulse`, `frame_start` and `odd_frame` are all 0.
- R2: The block locks when three conditions hold. Bits 2..8 of timeslot 0 equal `0011011` in frame N, with bit 2 received first. That word is absent at the same position in frame N+1. It is present again in frame N+2. `in_frame` rises in the clock after the last bit of timeslot 0 of frame N+2 is taken.
- R3: If the alignment word also appears in frame N+1, the candidate is rejected and no lock is declared. A stream carrying the word in every frame never locks.
- R4: If the alignment word is missing in frame N+2, the block returns to search. It locks on a later candidate when the criteria of R2 are met.
- R5: While locked, three consecutive alignment words received in error drop `in_frame`. The drop happens in the clock after the last bit of timeslot 0 of the third errored frame. A correct alignment word restarts the count.
- R6: With `alt_loss_en` = 0, a bit 2 of 0 in odd frames has no effect on lock.
- R7: With `alt_loss_en` = 1, three consecutive odd frames with bit 2 = 0 drop `in_frame` at the last bit of timeslot 0 of the third. An odd frame with bit 2 = 1 restarts that count.
- R8: Each loss of lock raises `resync_pulse` for exactly one clock, in the same clock that `in_frame` falls.
- R9: While locked:
  - `slot_idx` and `bit_idx` (0..7) give the position of the bit currently on `rx_data`.
  - `frame_start` is 1 exactly when that position is slot 0, bit 0.
  - `odd_frame` is 1 during frames that do not carry the alignment word.
- R10: After a loss, the block searches again and relocks on the stream by the criteria of R2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Recovered bit clock, one line bit per rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_data | input | 1 | Serial receive bit |
| alt_loss_en | input | 1 | Adds the odd-frame bit-2 loss criterion |
| in_frame | output | 1 | Basic frame lock |
| frame_start | output | 1 | Current bit is the first bit of a frame (locked only) |
| odd_frame | output | 1 | Current frame carries no alignment word (locked only) |
| resync_pulse | output | 1 | One-clock pulse on each loss of lock |
| slot_idx | output | 5 | Timeslot of the current bit |
| bit_idx | output | 3 | Bit number (0..7) of the current bit within its timeslot |

## Verification
Every lock or loss decision is taken on the edge that consumes the last bit of timeslot 0. `in_frame` and the position outputs reflect it one register later, so the change is visible right after that same edge. The resync pulse comes from one further register fed by the next state, so it appears in that same clock and clears on the next edge. The bench drives a bit at the falling edge and samples shortly after the rising edge that consumes it. It computes lock, pulse, slot, bit, start and parity from the frame and bit index of the bit just sent. These values are compared after every bit, so a decision that lands one bit early or late, or one frame early or late, is caught.

// File: rtl/e1fa_pkg.sv
package e1fa_pkg;

    typedef enum logic [1:0] {
        ST_HUNT    = 2'd0,
        ST_GAP     = 2'd1,
        ST_CONFIRM = 2'd2,
        ST_LOCKED  = 2'd3
    } fa_state_e;

endpackage

// File: rtl/e1fa_word_detect.sv
// Sliding window over the last WORD_W received bits (current bit included).
// The oldest bit of the window corresponds to bit 2 of timeslot 0 when the
// current bit is the last bit of timeslot 0.
module e1fa_word_detect #(
    parameter int          WORD_W  = 7,
    parameter logic [WORD_W-1:0] PATTERN = 7'b0011011
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rx_data,
    output logic word_hit,
    output logic oldest_bit
);

    localparam int HIST_W = WORD_W - 1;

    logic [HIST_W-1:0] hist_q;
    logic [WORD_W-1:0] window;

    assign window     = {hist_q, rx_data};
    assign word_hit   = (window == PATTERN);
    assign oldest_bit = window[WORD_W-1];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hist_q <= '1;
        end else begin
            hist_q <= window[HIST_W-1:0];
        end
    end

endmodule

// File: rtl/e1fa_position.sv
// Free-running bit position within the hypothesised frame, reloaded by the
// aligner when a new candidate is taken.
module e1fa_position #(
    parameter int SLOTS     = 32,
    parameter int SLOT_BITS = 8
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         load,
    output logic [$clog2(SLOTS)-1:0]     slot_idx,
    output logic [$clog2(SLOT_BITS)-1:0] bit_idx,
    output logic                         ts0_last,
    output logic                         odd_q
);

    localparam int FRAME_BITS = SLOTS * SLOT_BITS;
    localparam int POS_W      = $clog2(FRAME_BITS);
    localparam int BIT_W      = $clog2(SLOT_BITS);

    logic [POS_W-1:0] pos_q;
    logic             wrap;

    assign wrap     = (pos_q == POS_W'(FRAME_BITS - 1));
    assign slot_idx = pos_q[POS_W-1:BIT_W];
    assign bit_idx  = pos_q[BIT_W-1:0];
    assign ts0_last = (pos_q == POS_W'(SLOT_BITS - 1));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pos_q <= '0;
            odd_q <= 1'b0;
        end else if (load) begin
            pos_q <= POS_W'(SLOT_BITS);
            odd_q <= 1'b0;
        end else if (wrap) begin
            pos_q <= '0;
            odd_q <= ~odd_q;
        end else begin
            pos_q <= pos_q + 1'b1;
        end
    end

endmodule

// File: rtl/e1fa_err_count.sv
// Consecutive-error counter: trips on the LIMIT-th bad event in a row.
module e1fa_err_count #(
    parameter int LIMIT = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic ok,
    input  logic bad,
    output logic trip
);

    localparam int CW = $clog2(LIMIT + 1);

    logic [CW-1:0] cnt_q;

    assign trip = bad && (cnt_q == CW'(LIMIT - 1));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clr || ok || trip) begin
            cnt_q <= '0;
        end else if (bad) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

endmodule

// File: rtl/e1_frame_aligner.sv
module e1_frame_aligner #(
    parameter int SLOTS      = 32,
    parameter int SLOT_BITS  = 8,
    parameter int LOSS_LIMIT = 3,
    parameter logic [SLOT_BITS-2:0] FAS_WORD = 7'b0011011
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         rx_data,
    input  logic                         alt_loss_en,
    output logic                         in_frame,
    output logic                         frame_start,
    output logic                         odd_frame,
    output logic                         resync_pulse,
    output logic [$clog2(SLOTS)-1:0]     slot_idx,
    output logic [$clog2(SLOT_BITS)-1:0] bit_idx
);

    import e1fa_pkg::*;

    localparam int WORD_W = SLOT_BITS - 1;
    localparam int SLOT_W = $clog2(SLOTS);
    localparam int BIT_W  = $clog2(SLOT_BITS);

    fa_state_e state_q, state_d;

    logic              word_hit;
    logic              bit2_val;
    logic              pos_load;
    logic              ts0_last;
    logic              odd_q;
    logic [SLOT_W-1:0] slot_w;
    logic [BIT_W-1:0]  bit_w;
    logic              fas_ok, fas_bad, fas_trip;
    logic              nfas_ok, nfas_bad, nfas_trip;
    logic              cnt_clr, nfas_clr;
    logic              resync_q;

    e1fa_word_detect #(
        .WORD_W (WORD_W),
        .PATTERN(FAS_WORD)
    ) u_detect (
        .clk       (clk),
        .rst_n     (rst_n),
        .rx_data   (rx_data),
        .word_hit  (word_hit),
        .oldest_bit(bit2_val)
    );

    e1fa_position #(
        .SLOTS    (SLOTS),
        .SLOT_BITS(SLOT_BITS)
    ) u_pos (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (pos_load),
        .slot_idx(slot_w),
        .bit_idx (bit_w),
        .ts0_last(ts0_last),
        .odd_q   (odd_q)
    );

    // Loss monitors evaluate only while locked, on the last bit of timeslot 0.
    assign cnt_clr  = (state_q != ST_LOCKED);
    assign nfas_clr = cnt_clr || !alt_loss_en;
    assign fas_ok   = (state_q == ST_LOCKED) && ts0_last && !odd_q && word_hit;
    assign fas_bad  = (state_q == ST_LOCKED) && ts0_last && !odd_q && !word_hit;
    assign nfas_ok  = (state_q == ST_LOCKED) && ts0_last && odd_q && bit2_val;
    assign nfas_bad = (state_q == ST_LOCKED) && ts0_last && odd_q && !bit2_val;

    e1fa_err_count #(.LIMIT(LOSS_LIMIT)) u_fas_cnt (
        .clk  (clk),
        .rst_n(rst_n),
        .clr  (cnt_clr),
        .ok   (fas_ok),
        .bad  (fas_bad),
        .trip (fas_trip)
    );

    e1fa_err_count #(.LIMIT(LOSS_LIMIT)) u_nfas_cnt (
        .clk  (clk),
        .rst_n(rst_n),
        .clr  (nfas_clr),
        .ok   (nfas_ok),
        .bad  (nfas_bad),
        .trip (nfas_trip)
    );

    // Next-state logic: transitions hunt_hit, gap_ok, gap_fail, confirm_ok,
    // confirm_fail and loss.
    always_comb begin
        state_d  = state_q;
        pos_load = 1'b0;
        unique case (state_q)
            ST_HUNT: begin
                if (word_hit) begin
                    state_d  = ST_GAP;
                    pos_load = 1'b1;
                end
            end
            ST_GAP: begin
                if (ts0_last) begin
                    state_d = word_hit ? ST_HUNT : ST_CONFIRM;
                end
            end
            ST_CONFIRM: begin
                if (ts0_last) begin
                    state_d = word_hit ? ST_LOCKED : ST_HUNT;
                end
            end
            ST_LOCKED: begin
                if (fas_trip || (alt_loss_en && nfas_trip)) begin
                    state_d = ST_HUNT;
                end
            end
            default: state_d = ST_HUNT;
        endcase
    end

    // State register and the registered loss event.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= ST_HUNT;
            resync_q <= 1'b0;
        end else begin
            state_q  <= state_d;
            resync_q <= (state_q == ST_LOCKED) && (state_d == ST_HUNT);
        end
    end

    // Outputs.
    always_comb begin
        in_frame     = (state_q == ST_LOCKED);
        frame_start  = in_frame && (slot_w == '0) && (bit_w == '0);
        odd_frame    = in_frame && odd_q;
        resync_pulse = resync_q;
        slot_idx     = slot_w;
        bit_idx      = bit_w;
    end

endmodule

// File: rtl/e1fa_checker.sv
module e1fa_checker #(
    parameter int SLOT_W = 5,
    parameter int BIT_W  = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              in_frame,
    input logic              frame_start,
    input logic              odd_frame,
    input logic              resync_pulse,
    input logic [SLOT_W-1:0] slot_idx,
    input logic [BIT_W-1:0]  bit_idx
);

    // R2: lock appears right after the last bit of timeslot 0.
    p_lock_position_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(in_frame) |-> (slot_idx == SLOT_W'(1)) && (bit_idx == '0));

    // R5: loss is taken at the same point of the frame.
    p_loss_position_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(in_frame) |-> (slot_idx == SLOT_W'(1)) && (bit_idx == '0));

    // R8: resync pulse is one clock wide.
    p_pulse_width_r8: assert property (@(posedge clk) disable iff (!rst_n)
        resync_pulse |=> !resync_pulse);

    // R8: pulse coincides with the fall of in_frame.
    p_pulse_on_fall_r8: assert property (@(posedge clk) disable iff (!rst_n)
        resync_pulse |-> !in_frame && $past(in_frame));

    // R8: no loss of lock without a pulse.
    p_fall_has_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(in_frame) |-> resync_pulse);

    // R9: frame start only at slot 0 bit 0 while locked.
    p_frame_start_r9: assert property (@(posedge clk) disable iff (!rst_n)
        frame_start |-> in_frame && (slot_idx == '0) && (bit_idx == '0));

    // R9: parity alternates at each frame boundary while locked.
    p_odd_toggle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_start && $past(in_frame)) |-> (odd_frame != $past(odd_frame)));

endmodule

bind e1_frame_aligner e1fa_checker #(
    .SLOT_W(SLOT_W),
    .BIT_W (BIT_W)
) u_e1fa_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .in_frame    (in_frame),
    .frame_start (frame_start),
    .odd_frame   (odd_frame),
    .resync_pulse(resync_pulse),
    .slot_idx    (slot_idx),
    .bit_idx     (bit_idx)
);

// File: tb/e1_frame_aligner_tb_top.sv
module e1_frame_aligner_tb_top;

    localparam logic [6:0] FAS = 7'b0011011;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rx_data = 1'b1;
    logic       alt_loss_en = 1'b0;
    logic       in_frame, frame_start, odd_frame, resync_pulse;
    logic [4:0] slot_idx;
    logic [2:0] bit_idx;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #2 clk = ~clk;

    e1_frame_aligner dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .rx_data     (rx_data),
        .alt_loss_en (alt_loss_en),
        .in_frame    (in_frame),
        .frame_start (frame_start),
        .odd_frame   (odd_frame),
        .resync_pulse(resync_pulse),
        .slot_idx    (slot_idx),
        .bit_idx     (bit_idx)
    );

    task automatic check(input string req, input string what, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
        end
    endtask

    task automatic send(input logic v);
        @(negedge clk) rx_data = v;
        @(posedge clk);
        #1;
    endtask

    task automatic do_reset(input logic alt);
        @(negedge clk);
        rst_n = 1'b0;
        rx_data = 1'b1;
        alt_loss_en = alt;
        repeat (3) @(posedge clk);
        #1;
        rst_n = 1'b1;
        check("R1", "in_frame after reset", int'(in_frame), 0);
        check("R1", "resync after reset", int'(resync_pulse), 0);
        check("R1", "frame_start after reset", int'(frame_start), 0);
        check("R1", "odd_frame after reset", int'(odd_frame), 0);
    endtask

    // Stream: payload all ones; TS0 of even frames is Si=1 then the FAS word;
    // TS0 of odd frames is all ones except bit 2 when errored.
    function automatic logic frame_bit(input int f, input int p, input logic [31:0] fas_bad,
                                       input logic [31:0] b2_bad, input logic [31:0] all_fas);
        logic b;
        if (p >= 8 || p == 0) return 1'b1;
        if ((f % 2) == 0 || all_fas[f]) begin
            b = FAS[7 - p];
            if ((f % 2) == 0 && fas_bad[f] && p == 7) b = ~b;
            return b;
        end
        if (p == 1) return ~b2_bad[f];
        return 1'b1;
    endfunction

    task automatic run_case(input string req, input int off, input logic alt,
                            input logic [31:0] fas_bad, input logic [31:0] b2_bad,
                            input logic [31:0] all_fas, input int nframes,
                            input int sync_f, input int loss_f, input int relock_f);
        do_reset(alt);
        for (int i = 0; i < off; i++) begin
            send(1'b1);
            check(req, "in_frame in preamble", int'(in_frame), 0);
        end
        for (int f = 0; f < nframes; f++) begin
            for (int p = 0; p < 256; p++) begin
                int  k, np, nf;
                bit  exp_in, exp_rs;
                send(frame_bit(f, p, fas_bad, b2_bad, all_fas));
                k  = f * 256 + p;
                np = (p + 1) % 256;
                nf = (p == 255) ? f + 1 : f;
                exp_in = (sync_f >= 0 && k >= sync_f * 256 + 7 &&
                          (loss_f < 0 || k < loss_f * 256 + 7)) ||
                         (relock_f >= 0 && k >= relock_f * 256 + 7);
                exp_rs = (loss_f >= 0 && k == loss_f * 256 + 7);
                check(req, "in_frame", int'(in_frame), int'(exp_in));
                check("R8", "resync_pulse", int'(resync_pulse), int'(exp_rs));
                if (exp_in) begin
                    check("R9", "slot_idx", int'(slot_idx), np / 8);
                    check("R9", "bit_idx", int'(bit_idx), np % 8);
                    check("R9", "frame_start", int'(frame_start), int'(np == 0));
                    check("R9", "odd_frame", int'(odd_frame), nf % 2);
                end else begin
                    check("R9", "frame_start unlocked", int'(frame_start), 0);
                end
            end
        end
    endtask

    initial begin
        // R2 / R9: sweep of bit offsets and both loss modes on a clean stream.
        for (int off = 0; off < 8; off++) begin
            for (int m = 0; m < 2; m++) begin
                run_case("R2", off * 37, logic'(m), 32'h0, 32'h0, 32'h0, 5, 2, -1, -1);
            end
        end
        // R3: alignment word in every frame never locks.
        run_case("R3", 5, 1'b0, 32'h0, 32'h0, 32'hFFFF_FFFF, 8, -1, -1, -1);
        // R4: missing word in frame 2 restarts search, lock at frame 6.
        run_case("R4", 3, 1'b0, 32'h4, 32'h0, 32'h0, 8, 6, -1, -1);
        // R5 R6 R10: mode clear, bit-2 errors ignored, FAS errors 4,6 (8 good) 10,12,14.
        run_case("R5 R6 R10", 11, 1'b0,
                 (32'h1 << 4) | (32'h1 << 6) | (32'h1 << 10) | (32'h1 << 12) | (32'h1 << 14),
                 (32'h1 << 3) | (32'h1 << 5) | (32'h1 << 7) | (32'h1 << 9) | (32'h1 << 11),
                 32'h0, 20, 2, 14, 18);
        // R7 R10: mode set, bit-2 errors 3,5 (7 good) 9,11,13.
        run_case("R7 R10", 2, 1'b1, 32'h0,
                 (32'h1 << 3) | (32'h1 << 5) | (32'h1 << 9) | (32'h1 << 11) | (32'h1 << 13),
                 32'h0, 18, 2, 13, 16);
        // R5: FAS criterion still active with mode set.
        run_case("R5", 0, 1'b1, (32'h1 << 4) | (32'h1 << 6) | (32'h1 << 8), 32'h0, 32'h0,
                 14, 2, 8, 12);
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        #(4 * 190000);
        if (!done) begin
            done = 1'b1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

endmodule